// File: doc/BRIEF.md
# Predicated Halfword Scatter-Store Sequencer

This block turns one vector scatter-store command into a series of 16-bit memory writes. A command carries a vector of per-element base addresses, a vector of source values, a byte-granular predicate, an element-width select and a 5-bit immediate. The sequencer visits the elements in index order and skips those whose predicate is clear. For each remaining element it issues one write over a valid/ready request port. The address of that write is the element base, zero-extended to 64 bits, plus twice the immediate. The data is the low halfword of the element's source value.

The command is accepted with a single-cycle `start` while the block is idle. When the command is finished, or has nothing to write, the block raises a one-cycle `done`. A command issued in streaming mode without the full-feature enable is refused with a one-cycle `illegal` pulse and has no other effect. The vector length is a parameter (default 256 bits).

Top module: `hw_scatter_seq`

## Requirements
- R1: Each write address equals the 64-bit sum of the element base and `cmd_imm` × 2, wrapping modulo 2^64, so the offset runs from 0 to 62 in steps of 2.
- R2: With `cmd_wide` = 0 the elements are 32 bits wide and there are VLEN/32 of them; each base is zero-extended from 32 to 64 bits. With `cmd_wide` = 1 the elements are 64 bits wide and there are VLEN/64 of them.
- R3: Each write carries bits [15:0] of the matching source element in `wr_data`, with `wr_be` = 2'b11.
- R4: Element e is active when `cmd_pred` bit e×(element width/8) is 1. The other predicate bits have no effect. An inactive element produces no write.
- R5: Writes for the active elements are issued in ascending element index order, one per active element, with nothing else issued.
- R6: When no element is active, `done` is high in the cycle after the `start` edge and no write is issued.
- R7: A `start` with `mode_streaming` = 1 and `mode_full_en` = 0 gives `illegal` high for one cycle after the `start` edge, with no write and no `done`. With `mode_full_en` = 1 the command runs normally.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values. The sequencer moves to the next element only after a cycle in which both are high.
- R9: `done` is high for exactly one cycle, in the cycle after the last write is accepted, and `wr_valid` is low in that cycle.
- R10: `busy` is high from the cycle after an accepted `start` that has active elements until the last write is accepted. A `start` seen while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Command strobe, taken when idle |
| cmd_wide | input | 1 | Element width select: 0 = 32-bit, 1 = 64-bit |
| cmd_imm | input | 5 | Immediate; the byte offset is twice this value |
| cmd_pred | input | VLEN/8 | Predicate, one bit per vector byte |
| cmd_base | input | VLEN | Per-element base addresses |
| cmd_src | input | VLEN | Per-element source values |
| mode_streaming | input | 1 | Streaming-mode indication |
| mode_full_en | input | 1 | Full-feature enable for streaming mode |
| busy | output | 1 | A command is issuing writes |
| wr_valid | output | 1 | Write request valid |
| wr_ready | input | 1 | Memory accepts the request |
| wr_addr | output | 64 | Write byte address |
| wr_data | output | 16 | Write halfword |
| wr_be | output | 2 | Byte enables |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle rejection pulse |

## Verification
On every cycle the assertions check the request-port rules. A stalled request must keep its address and data. The byte enables must be all ones. `done` and `illegal` must never overlap with a pending request, and `done` must always find the block idle. Address arithmetic, zero extension, predicate bit selection, ascending order and the number of writes can only be shown by the bench. It sweeps every element mask in both widths across all immediates, sets noise in the ignored predicate bits, and compares each accepted write against values it computes itself. The bench scenarios also cover the rejected and empty commands and a command issued while busy.

// File: rtl/scat_pkg.sv
// Shared types for the scatter-store sequencer.
// Assumes nothing beyond a standard SystemVerilog compiler.
package scat_pkg;
    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    localparam int unsigned HALF_BYTES = 2;
endpackage

// File: rtl/scat_pred_decode.sv
// Predicate decode: reduces the byte-granular predicate to one active bit per
// element slot for the selected element width. Slots beyond the element count
// of the 64-bit width read as inactive.
// Assumes VLEN is a multiple of 64.
module scat_pred_decode #(
    parameter int unsigned VLEN = 256,
    localparam int unsigned PW  = VLEN / 8,
    localparam int unsigned NE  = VLEN / 32
) (
    input  logic          wide,
    input  logic [PW-1:0] pred,
    output logic [NE-1:0] act
);
    genvar e;
    generate
        for (e = 0; e < NE; e++) begin : g_slot
            if (e < NE / 2) begin : g_both
                // Pick the lowest predicate bit of the element group.
                assign act[e] = wide ? pred[e * 8] : pred[e * 4];
            end else begin : g_narrow
                // Only 32-bit elements reach this slot.
                assign act[e] = wide ? 1'b0 : pred[e * 4];
            end
        end
    endgenerate
endmodule

// File: rtl/scat_lowest_pick.sv
// Lowest-set-bit picker: finds the smallest index with a set bit and returns it
// both as an index and as a one-hot mask.
// Assumes N >= 2.
module scat_lowest_pick #(
    parameter int unsigned N  = 8,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          found,
    output logic [IW-1:0] idx,
    output logic [N-1:0]  onehot
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        found  = 1'b0;
        idx    = '0;
        onehot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found  = 1'b1;
                idx    = IW'(i);
                onehot = N'(1) << i;
            end
        end
    end
endmodule

// File: rtl/scat_elem_fetch.sv
// Element fetch: selects the base and source of one element from the captured
// vectors and forms the halfword write address and data.
// Assumes idx is below the element count of the selected width.
module scat_elem_fetch #(
    parameter int unsigned VLEN = 256,
    localparam int unsigned NE  = VLEN / 32,
    localparam int unsigned IW  = $clog2(NE)
) (
    input  logic            wide,
    input  logic [IW-1:0]   idx,
    input  logic [4:0]      imm,
    input  logic [VLEN-1:0] base_vec,
    input  logic [VLEN-1:0] src_vec,
    output logic [63:0]     addr,
    output logic [15:0]     data
);
    logic [63:0] base_ext;
    logic [63:0] offset;

    // Choose and zero-extend the element base and low halfword of the source.
    always_comb begin
        if (wide) begin
            base_ext = base_vec[int'(idx) * 64 +: 64];
            data     = src_vec[int'(idx) * 64 +: 16];
        end else begin
            base_ext = {32'd0, base_vec[int'(idx) * 32 +: 32]};
            data     = src_vec[int'(idx) * 32 +: 16];
        end
    end

    // Scale the immediate by the halfword size and add.
    always_comb begin
        offset = 64'(imm) * 64'(scat_pkg::HALF_BYTES);
        addr   = base_ext + offset;
    end
endmodule

// File: rtl/hw_scatter_seq.sv
// Scatter-store sequencer top: accepts a command, captures the vectors when at
// least one element is active, then issues one halfword write per active
// element in ascending order over a valid/ready port.
// Assumes VLEN is a multiple of 64; synchronous active-low reset.
module hw_scatter_seq #(
    parameter int unsigned VLEN = 256,
    localparam int unsigned PW  = VLEN / 8,
    localparam int unsigned NE  = VLEN / 32,
    localparam int unsigned IW  = $clog2(NE)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            cmd_wide,
    input  logic [4:0]      cmd_imm,
    input  logic [PW-1:0]   cmd_pred,
    input  logic [VLEN-1:0] cmd_base,
    input  logic [VLEN-1:0] cmd_src,
    input  logic            mode_streaming,
    input  logic            mode_full_en,
    output logic            busy,
    output logic            wr_valid,
    input  logic            wr_ready,
    output logic [63:0]     wr_addr,
    output logic [15:0]     wr_data,
    output logic [1:0]      wr_be,
    output logic            done,
    output logic            illegal
);
    import scat_pkg::*;

    seq_state_e      state_q;
    logic [NE-1:0]   act_in;
    logic [NE-1:0]   rem_q;
    logic [VLEN-1:0] base_q;
    logic [VLEN-1:0] src_q;
    logic            wide_q;
    logic [4:0]      imm_q;
    logic            done_q;
    logic            illegal_q;
    logic            pick_found;
    logic [IW-1:0]   pick_idx;
    logic [NE-1:0]   pick_oh;
    logic [NE-1:0]   rem_next;
    logic            legal;
    logic            fire;
    logic            unused_pred;

    // Predicate bits outside the lowest of each group carry no meaning.
    assign unused_pred = ^cmd_pred;

    scat_pred_decode #(.VLEN(VLEN)) dec_i (
        .wide (cmd_wide),
        .pred (cmd_pred),
        .act  (act_in)
    );

    scat_lowest_pick #(.N(NE)) pick_i (
        .vec    (rem_q),
        .found  (pick_found),
        .idx    (pick_idx),
        .onehot (pick_oh)
    );

    scat_elem_fetch #(.VLEN(VLEN)) fetch_i (
        .wide     (wide_q),
        .idx      (pick_idx),
        .imm      (imm_q),
        .base_vec (base_q),
        .src_vec  (src_q),
        .addr     (wr_addr),
        .data     (wr_data)
    );

    // Command legality and request handshake.
    always_comb begin
        legal    = !(mode_streaming && !mode_full_en);
        wr_valid = (state_q == SEQ_RUN) && pick_found;
        fire     = wr_valid && wr_ready;
        rem_next = rem_q & ~pick_oh;
    end

    // Sequencer state, captured command and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SEQ_IDLE;
            rem_q     <= '0;
            base_q    <= '0;
            src_q     <= '0;
            wide_q    <= 1'b0;
            imm_q     <= '0;
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            illegal_q <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        if (!legal) begin
                            illegal_q <= 1'b1;
                        end else if (act_in == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            base_q  <= cmd_base;
                            src_q   <= cmd_src;
                            wide_q  <= cmd_wide;
                            imm_q   <= cmd_imm;
                            rem_q   <= act_in;
                            state_q <= SEQ_RUN;
                        end
                    end
                end
                SEQ_RUN: begin
                    if (fire) begin
                        rem_q <= rem_next;
                        if (rem_next == '0) begin
                            state_q <= SEQ_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Output drive.
    always_comb begin
        busy    = (state_q == SEQ_RUN);
        wr_be   = 2'b11;
        done    = done_q;
        illegal = illegal_q;
    end
endmodule

// File: rtl/hw_scatter_seq_chk.sv
// Protocol checker for the scatter-store sequencer, bound to every instance.
// Assumes the synchronous active-low reset of the top.
module hw_scatter_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [63:0] wr_addr,
    input logic [15:0] wr_data,
    input logic [1:0]  wr_be,
    input logic        done,
    input logic        illegal
);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    assert_be_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> wr_be == 2'b11);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_valid && !busy);

    assert_illegal_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_valid && !done && !busy);

    assert_valid_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> busy);
endmodule

bind hw_scatter_seq hw_scatter_seq_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .done     (done),
    .illegal  (illegal)
);

// File: tb/hw_scatter_seq_tb_top.sv
// Sweep bench: every element mask in both widths, all immediates, noisy
// ignored predicate bits and varying ready stalls, with expected writes
// computed arithmetically.
module hw_scatter_seq_tb_top;
    localparam int VLEN = 256;
    localparam int PW   = VLEN / 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            cmd_wide = 1'b0;
    logic [4:0]      cmd_imm = '0;
    logic [PW-1:0]   cmd_pred = '0;
    logic [VLEN-1:0] cmd_base = '0;
    logic [VLEN-1:0] cmd_src = '0;
    logic            mode_streaming = 1'b0;
    logic            mode_full_en = 1'b0;
    logic            busy;
    logic            wr_valid;
    logic            wr_ready = 1'b0;
    logic [63:0]     wr_addr;
    logic [15:0]     wr_data;
    logic [1:0]      wr_be;
    logic            done;
    logic            illegal;

    int checks = 0;
    int errors = 0;
    int rdy_cnt = 0;

    always #2.5 clk = ~clk;

    hw_scatter_seq #(.VLEN(VLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_wide(cmd_wide),
        .cmd_imm(cmd_imm), .cmd_pred(cmd_pred), .cmd_base(cmd_base),
        .cmd_src(cmd_src), .mode_streaming(mode_streaming),
        .mode_full_en(mode_full_en), .busy(busy), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .done(done), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Fill base/source vectors and predicate from a seed; noise in ignored bits.
    task automatic load_cmd(input bit wide, input logic [7:0] emask,
                            input logic [4:0] imm, input int seed);
        logic [PW-1:0] p;
        p = PW'(32'h6B5A_C3D1 * (seed + 7));
        for (int e = 0; e < VLEN / 32; e++) begin
            if (wide) begin
                if (e < VLEN / 64) p[e * 8] = emask[e];
            end else begin
                p[e * 4] = emask[e];
            end
        end
        for (int i = 0; i < VLEN / 32; i++) begin
            cmd_base[i * 32 +: 32] = 32'h9E37_79B9 * (i + 1) + 32'h0001_0003 * seed
                                     + ((i % 3 == 2) ? 32'hFFFF_FFF0 : 32'd0);
            cmd_src[i * 32 +: 32]  = 32'h85EB_CA6B * (i + 3) ^ (seed << 4);
        end
        cmd_pred = p;
        cmd_wide = wide;
        cmd_imm  = imm;
    endtask

    // Expected address and data for element e of the current command vectors.
    function automatic logic [63:0] exp_addr(input logic [VLEN-1:0] b, input bit wide,
                                             input int e, input logic [4:0] imm);
        logic [63:0] base;
        base = wide ? b[e * 64 +: 64] : {32'd0, b[e * 32 +: 32]};
        return base + 64'(imm) * 64'd2;
    endfunction

    function automatic logic [15:0] exp_data(input logic [VLEN-1:0] s, input bit wide,
                                             input int e);
        return wide ? s[e * 64 +: 16] : s[e * 32 +: 16];
    endfunction

    // Issue one command and check every write it produces.
    task automatic run_cmd(input bit wide, input logic [7:0] emask,
                           input logic [4:0] imm, input int seed, input bit poke);
        logic [VLEN-1:0] b;
        logic [VLEN-1:0] s;
        logic [7:0]      m;
        int ne;
        int nact;
        int k;
        int guard;
        int e;
        ne = wide ? VLEN / 64 : VLEN / 32;
        m  = emask & 8'((1 << ne) - 1);
        nact = $countones(m);
        load_cmd(wide, emask, imm, seed);
        b = cmd_base;
        s = cmd_src;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (nact == 0) begin
            check(done && !wr_valid && !busy, "R6 empty done", {62'd0, done, wr_valid}, 64'd2);
            @(negedge clk);
            check(!done, "R9 done one cycle", 64'(done), 64'd0);
            return;
        end
        check(busy && wr_valid, "R10 busy after start", {62'd0, busy, wr_valid}, 64'd3);
        if (poke) begin
            load_cmd(!wide, 8'hFF, imm + 5'd3, seed + 99);
            start = 1'b1;
        end
        k = 0;
        e = 0;
        guard = 0;
        while (k < nact) begin
            bit rdy;
            rdy_cnt++;
            rdy = ((rdy_cnt % 5) != 1) && ((rdy_cnt % 7) != 3);
            if (wr_valid && rdy) begin
                while (!m[e]) e++;
                check(wr_addr == exp_addr(b, wide, e, imm), "R1 R2 R5 addr", wr_addr,
                      exp_addr(b, wide, e, imm));
                check(wr_data == exp_data(s, wide, e) && wr_be == 2'b11, "R3 R4 data",
                      {46'd0, wr_be, wr_data}, {46'd0, 2'b11, exp_data(s, wide, e)});
                e++;
                k++;
            end
            wr_ready = rdy;
            @(negedge clk);
            start = 1'b0;
            guard++;
            if (guard > 400) begin
                check(1'b0, "R8 progress", 64'(k), 64'(nact));
                return;
            end
        end
        wr_ready = 1'b0;
        check(done && !wr_valid && !busy, "R9 R5 done after last", {62'd0, done, wr_valid},
              64'd2);
        @(negedge clk);
        check(!done && !wr_valid, "R9 single pulse", {62'd0, done, wr_valid}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !wr_valid && !done && !illegal, "reset state",
              {60'd0, busy, wr_valid, done, illegal}, 64'd0);

        // R7: refused in streaming mode without the full-feature enable.
        mode_streaming = 1'b1;
        mode_full_en   = 1'b0;
        load_cmd(1'b0, 8'hFF, 5'd4, 1);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(illegal && !done && !wr_valid && !busy, "R7 refused",
              {61'd0, illegal, done, wr_valid}, 64'd4);
        @(negedge clk);
        check(!illegal && !wr_valid && !done, "R7 no effect", {61'd0, illegal, done, wr_valid},
              64'd0);
        mode_full_en = 1'b1;
        run_cmd(1'b0, 8'hA5, 5'd31, 2, 1'b0);
        check(!illegal, "R7 full enable runs", 64'(illegal), 64'd0);
        mode_streaming = 1'b0;
        mode_full_en   = 1'b0;

        // R10: start while busy ignored.
        run_cmd(1'b0, 8'h5A, 5'd7, 3, 1'b1);
        run_cmd(1'b1, 8'h0B, 5'd9, 4, 1'b1);

        // Sweep: every 32-bit element mask, every 64-bit mask, all immediates.
        for (int p = 0; p < 256; p++) run_cmd(1'b0, 8'(p), 5'(p), p + 10, 1'b0);
        for (int p = 0; p < 16; p++)  run_cmd(1'b1, {4'hF, 4'(p)}, 5'(31 - p), p + 300, 1'b0);
        for (int i = 0; i < 32; i++)  run_cmd(1'b1, 8'h09, 5'(i), i + 500, 1'b0);
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 64'd0, 64'd1);
        summary();
    end
endmodule